// File: doc/BRIEF.md
# Banked Channel Register Bridge

This block is the control-register front end of a multi-channel packet engine that sends each channel over two redundant links. A processor reaches it through an AXI4-Lite slave port. A few global registers are mapped directly. The per-channel parameters are not mapped one by one. Software first picks a link and a channel through a selector register. It then writes the parameter words into a shared staging window. Finally it pulses a commit bit, which copies the whole staged window into the active bank for that link and channel in a single clock. The datapath therefore never sees a half-updated parameter set.

The active storage has two parts. One bank entry exists for every link and channel pair, and it holds header, tag, address and port words. A second, smaller bank holds one entry per channel for the words that the two links share, such as stream identifiers and FEC settings. All committed words, and the global words, are driven as flat vectors to the datapath. A read of a window offset returns the committed word for the selected link and channel, not the staged word.

Top module: `chanbank_bridge`

## Requirements
- R1: After reset every register, staging word and bank word is zero. Every readable offset returns zero, and bValid and rValid are low.
- R2: The four global words at offsets 0x010, 0x014, 0x018 and 0x01C are read and written directly, with per-byte write strobes. They drive genCfg in that order: the word at 0x010 is bits [31:0] and the word at 0x01C is bits [127:96].
- R3: The selector at offset 0x00C holds the link in bit 24 (0 = primary, 1 = secondary) and the channel index in bits [1:0]. A read returns only those bits. All other bits read as zero.
- R4: Writes to the window (base 0x100, word slot = offset[5:2]) change only staging. The committed outputs and the window read-back keep their values until a commit.
- R5: Bit 1 of the control word at 0x000 is the commit bit, and it is the only bit that reads back. A commit happens on its 0-to-1 change. The staged words appear on linkCfg and chanCfg one clock after the write response of that control write, and not before. Writing the bit while it is already 1 does not commit.
- R6: On a commit, link-specific slots {0..5, 12, 13} are copied into the entry for the selected link and channel. Channel-shared slots {6..11} are copied into the shared entry for the selected channel, whichever link is selected. linkCfg holds word s of link l, channel c at bit ((l*4+c)*16+s)*32. chanCfg holds word s of channel c at bit (c*16+s)*32.
- R7: A read of a mapped window slot returns the committed word for the link and channel currently in the selector.
- R8: Unmapped offsets return zero on a read and ignore writes. This covers window slots 14 and 15, offsets that are not word aligned, and addresses outside the map. Every response is OKAY (00).
- R9: A write completes when the address and the data have both been accepted. They may arrive in the same cycle or in either order, and the result is the same in every case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awAddr | input | 12 | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bResp | output | 2 | Write response, always OKAY |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| arAddr | input | 12 | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response, always OKAY |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| genCfg | output | 128 | Global words |
| linkCfg | output | 4096 | Committed per-link, per-channel words |
| chanCfg | output | 2048 | Committed per-channel shared words |

## Verification
A wrong selector or a wrong slot mask does not stay hidden. It puts a staged word into the wrong entry of linkCfg or chanCfg on the clock after the commit response, and the full output sweep after all eight commits then finds the misplaced word. A commit detector that fires on the level instead of the edge shows up during the repeated-commit test: the entry changes before the bit is cleared. An early bank load shows up one cycle too soon at the response edge. Read-mux faults surface in the window read-back sweep, where every slot of every link and channel pair is compared with its committed value.

// File: rtl/chanbank_pkg.sv
package chanbank_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int STRB_W   = DATA_W / 8;
  localparam int SLOTS    = 16;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int GEN_REGS = 4;
  localparam int GEN_W    = $clog2(GEN_REGS);

  // slot classes inside the channel window
  localparam logic [SLOTS-1:0] LINK_SLOTS = 16'h303F;
  localparam logic [SLOTS-1:0] CHAN_SLOTS = 16'h0FC0;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SEL  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_GEN  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_WIN  = 12'h100;

  localparam int SEL_LINK_LSB = 24;
  localparam int COMMIT_BIT   = 1;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [STRB_W-1:0] wrStrb;
    logic [ADDR_W-1:0] rdAddr;
  } busStrobe_t;

  function automatic logic [DATA_W-1:0] mergeBytes(input logic [DATA_W-1:0] oldVal,
                                                   input logic [DATA_W-1:0] newVal,
                                                   input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] res;
    res = oldVal;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) res[b*8 +: 8] = newVal[b*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/chanbank_axil_ctrl.sv
module chanbank_axil_ctrl
  import chanbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic              wValid,
  output logic              wReady,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [DATA_W-1:0] rData,
  output logic              rValid,
  input  logic              rReady,
  input  logic [DATA_W-1:0] rdWord,
  output busStrobe_t        strobe
);
  logic              awHeld, wHeld;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [STRB_W-1:0] strbQ;
  logic              doWrite;

  assign awReady = !awHeld;
  assign wReady  = !wHeld;
  assign arReady = !rValid;
  assign doWrite = awHeld && wHeld && !bValid;

  always_comb begin
    strobe.wrEn   = doWrite;
    strobe.wrAddr = addrQ;
    strobe.wrData = dataQ;
    strobe.wrStrb = strbQ;
    strobe.rdAddr = arAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awHeld <= 1'b0;
      wHeld  <= 1'b0;
      addrQ  <= '0;
      dataQ  <= '0;
      strbQ  <= '0;
      bValid <= 1'b0;
      rValid <= 1'b0;
      rData  <= '0;
    end else begin
      if (awValid && !awHeld) begin
        awHeld <= 1'b1;
        addrQ  <= awAddr;
      end
      if (wValid && !wHeld) begin
        wHeld <= 1'b1;
        dataQ <= wData;
        strbQ <= wStrb;
      end
      if (doWrite) begin
        awHeld <= 1'b0;
        wHeld  <= 1'b0;
        bValid <= 1'b1;
      end else if (bValid && bReady) begin
        bValid <= 1'b0;
      end
      if (arValid && !rValid) begin
        rValid <= 1'b1;
        rData  <= rdWord;
      end else if (rValid && rReady) begin
        rValid <= 1'b0;
      end
    end
  end

  a_r9_write_after_both: assert property (@(posedge clk) disable iff (!rstN)
    (awHeld && wHeld && !bValid) |=> bValid);
  a_r9_bresp_held: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid);
  a_r7_rdata_held: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData)));
  a_r7_rvalid_needs_ar: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rValid) |-> $past(arValid));
endmodule

// File: rtl/chanbank_regs.sv
module chanbank_regs
  import chanbank_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int NUM_LINK = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  busStrobe_t                                strobe,
  output logic [DATA_W-1:0]                         rdWord,
  output logic [GEN_REGS*DATA_W-1:0]                genCfg,
  output logic [NUM_LINK*NUM_CHAN*SLOTS*DATA_W-1:0] linkCfg,
  output logic [NUM_CHAN*SLOTS*DATA_W-1:0]          chanCfg
);
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam int LINK_W = (NUM_LINK > 1) ? $clog2(NUM_LINK) : 1;

  typedef struct packed {
    logic              isCtrl;
    logic              isSel;
    logic              isGen;
    logic              isWinLink;
    logic              isWinChan;
    logic [GEN_W-1:0]  genIdx;
    logic [SLOT_W-1:0] slot;
  } decode_t;

  function automatic decode_t decodeAddr(input logic [ADDR_W-1:0] a);
    decode_t d;
    logic aligned, inWin;
    aligned     = (a[1:0] == 2'b00);
    inWin       = aligned && (a[ADDR_W-1:6] == OFF_WIN[ADDR_W-1:6]);
    d.isCtrl    = (a == OFF_CTRL);
    d.isSel     = (a == OFF_SEL);
    d.isGen     = aligned && (a[ADDR_W-1:4] == OFF_GEN[ADDR_W-1:4]);
    d.genIdx    = a[2 +: GEN_W];
    d.slot      = a[2 +: SLOT_W];
    d.isWinLink = inWin && LINK_SLOTS[a[2 +: SLOT_W]];
    d.isWinChan = inWin && CHAN_SLOTS[a[2 +: SLOT_W]];
    return d;
  endfunction

  logic              commitBit, commitPrev, commitRise;
  logic [LINK_W-1:0] selLink;
  logic [CHAN_W-1:0] selChan;
  logic [DATA_W-1:0] genReg   [GEN_REGS];
  logic [DATA_W-1:0] stage    [SLOTS];
  logic [DATA_W-1:0] linkBank [NUM_LINK][NUM_CHAN][SLOTS];
  logic [DATA_W-1:0] chanBank [NUM_CHAN][SLOTS];

  decode_t           wrDec, rdDec;
  logic [DATA_W-1:0] ctrlWord, selWord, wrMerged;

  assign wrDec      = decodeAddr(strobe.wrAddr);
  assign rdDec      = decodeAddr(strobe.rdAddr);
  assign commitRise = commitBit && !commitPrev;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[COMMIT_BIT] = commitBit;
    selWord = '0;
    selWord[SEL_LINK_LSB +: LINK_W] = selLink;
    selWord[CHAN_W-1:0] = selChan;
  end

  always_comb begin
    if (wrDec.isCtrl)     wrMerged = mergeBytes(ctrlWord, strobe.wrData, strobe.wrStrb);
    else if (wrDec.isSel) wrMerged = mergeBytes(selWord, strobe.wrData, strobe.wrStrb);
    else if (wrDec.isGen) wrMerged = mergeBytes(genReg[wrDec.genIdx], strobe.wrData, strobe.wrStrb);
    else                  wrMerged = mergeBytes(stage[wrDec.slot], strobe.wrData, strobe.wrStrb);
  end

  // control, selector, global words and staging
  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitBit  <= 1'b0;
      commitPrev <= 1'b0;
      selLink    <= '0;
      selChan    <= '0;
      for (int g = 0; g < GEN_REGS; g++) genReg[g] <= '0;
      for (int s = 0; s < SLOTS; s++) stage[s] <= '0;
    end else begin
      commitPrev <= commitBit;
      if (strobe.wrEn) begin
        if (wrDec.isCtrl) commitBit <= wrMerged[COMMIT_BIT];
        if (wrDec.isSel) begin
          selLink <= wrMerged[SEL_LINK_LSB +: LINK_W];
          selChan <= wrMerged[CHAN_W-1:0];
        end
        if (wrDec.isGen) genReg[wrDec.genIdx] <= wrMerged;
        if (wrDec.isWinLink || wrDec.isWinChan) stage[wrDec.slot] <= wrMerged;
      end
    end
  end

  // active banks, loaded only on a commit edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINK; l++)
        for (int c = 0; c < NUM_CHAN; c++)
          for (int s = 0; s < SLOTS; s++) linkBank[l][c][s] <= '0;
      for (int c = 0; c < NUM_CHAN; c++)
        for (int s = 0; s < SLOTS; s++) chanBank[c][s] <= '0;
    end else if (commitRise) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (LINK_SLOTS[s]) linkBank[selLink][selChan][s] <= stage[s];
        if (CHAN_SLOTS[s]) chanBank[selChan][s] <= stage[s];
      end
    end
  end

  always_comb begin
    rdWord = '0;
    if (rdDec.isCtrl)         rdWord = ctrlWord;
    else if (rdDec.isSel)     rdWord = selWord;
    else if (rdDec.isGen)     rdWord = genReg[rdDec.genIdx];
    else if (rdDec.isWinLink) rdWord = linkBank[selLink][selChan][rdDec.slot];
    else if (rdDec.isWinChan) rdWord = chanBank[selChan][rdDec.slot];
  end

  for (genvar g = 0; g < GEN_REGS; g++) begin : gGen
    assign genCfg[g*DATA_W +: DATA_W] = genReg[g];
  end
  for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
    for (genvar s = 0; s < SLOTS; s++) begin : gSlot
      assign chanCfg[(c*SLOTS+s)*DATA_W +: DATA_W] = chanBank[c][s];
      for (genvar l = 0; l < NUM_LINK; l++) begin : gLink
        assign linkCfg[((l*NUM_CHAN+c)*SLOTS+s)*DATA_W +: DATA_W] = linkBank[l][c][s];
      end
    end
  end

  a_r5_bank_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(linkCfg) || !$stable(chanCfg)) |-> $past(commitRise));
  a_r4_stage_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && (wrDec.isWinLink || wrDec.isWinChan) && !commitRise)
      |=> ($stable(linkCfg) && $stable(chanCfg)));
endmodule

// File: rtl/chanbank_bridge.sv
module chanbank_bridge
  import chanbank_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int NUM_LINK = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [ADDR_W-1:0]                         awAddr,
  input  logic                                      awValid,
  output logic                                      awReady,
  input  logic [DATA_W-1:0]                         wData,
  input  logic [STRB_W-1:0]                         wStrb,
  input  logic                                      wValid,
  output logic                                      wReady,
  output logic [1:0]                                bResp,
  output logic                                      bValid,
  input  logic                                      bReady,
  input  logic [ADDR_W-1:0]                         arAddr,
  input  logic                                      arValid,
  output logic                                      arReady,
  output logic [DATA_W-1:0]                         rData,
  output logic [1:0]                                rResp,
  output logic                                      rValid,
  input  logic                                      rReady,
  output logic [GEN_REGS*DATA_W-1:0]                genCfg,
  output logic [NUM_LINK*NUM_CHAN*SLOTS*DATA_W-1:0] linkCfg,
  output logic [NUM_CHAN*SLOTS*DATA_W-1:0]          chanCfg
);
  busStrobe_t        strobe;
  logic [DATA_W-1:0] rdWord;

  assign bResp = 2'b00;
  assign rResp = 2'b00;

  chanbank_axil_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rValid(rValid), .rReady(rReady),
    .rdWord(rdWord), .strobe(strobe)
  );

  chanbank_regs #(.NUM_CHAN(NUM_CHAN), .NUM_LINK(NUM_LINK)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdWord(rdWord),
    .genCfg(genCfg), .linkCfg(linkCfg), .chanCfg(chanCfg)
  );
endmodule

// File: tb/chanbank_bridge_tb.sv
module chanbank_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 2;
  localparam int NS = 16;
  localparam logic [15:0] LMASK = 16'h303F;
  localparam logic [15:0] CMASK = 16'h0FC0;

  logic clk = 1'b0, rstN = 1'b0;
  logic [11:0] awAddr = '0, arAddr = '0;
  logic awValid = 1'b0, wValid = 1'b0, arValid = 1'b0;
  logic [31:0] wData = '0;
  logic [3:0] wStrb = '0;
  logic bReady = 1'b1, rReady = 1'b1;
  logic awReady, wReady, bValid, arReady, rValid;
  logic [1:0] bResp, rResp;
  logic [31:0] rData;
  logic [127:0] genCfg;
  logic [NL*NC*NS*32-1:0] linkCfg;
  logic [NC*NS*32-1:0] chanCfg;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] expLink [NL][NC][NS];
  logic [31:0] expChan [NC][NS];
  logic [31:0] stageM [NS];

  chanbank_bridge u_dut (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .genCfg(genCfg), .linkCfg(linkCfg), .chanCfg(chanCfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] val(int l, int c, int s);
    return 32'h1000_0000 * (s + 1) + 32'h0101 * l + 32'h0011_0000 * c + 32'h7;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendAw(logic [11:0] a);
    bit hs;
    awAddr = a; awValid = 1'b1;
    while (1) begin hs = awReady; @(negedge clk); if (hs) break; end
    awValid = 1'b0;
  endtask

  task automatic sendW(logic [31:0] d, logic [3:0] st);
    bit hs;
    wData = d; wStrb = st; wValid = 1'b1;
    while (1) begin hs = wReady; @(negedge clk); if (hs) break; end
    wValid = 1'b0;
  endtask

  // returns at the first negedge where bValid is seen
  task automatic axiWrite(logic [11:0] a, logic [31:0] d, logic [3:0] st, int mode);
    @(negedge clk);
    if (mode == 0) begin
      fork sendAw(a); sendW(d, st); join
    end else if (mode == 1) begin
      sendAw(a); sendW(d, st);
    end else begin
      sendW(d, st); sendAw(a);
    end
    while (!bValid) @(negedge clk);
    checks++;
    if (bResp !== 2'b00) begin errors++; $display("FAIL R8 bresp actual=%b expected=00", bResp); end
  endtask

  task automatic axiRead(logic [11:0] a, output logic [31:0] d);
    bit hs;
    @(negedge clk);
    arAddr = a; arValid = 1'b1;
    while (1) begin hs = arReady; @(negedge clk); if (hs) break; end
    arValid = 1'b0;
    while (!rValid) @(negedge clk);
    d = rData;
  endtask

  task automatic readCheck(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    axiRead(a, d);
    check(req, d, exp);
  endtask

  function automatic logic [31:0] outLink(int l, int c, int s);
    return linkCfg[((l*NC+c)*NS+s)*32 +: 32];
  endfunction
  function automatic logic [31:0] outChan(int c, int s);
    return chanCfg[(c*NS+s)*32 +: 32];
  endfunction

  task automatic modelCommit(int l, int c);
    for (int s = 0; s < NS; s++) begin
      if (LMASK[s]) expLink[l][c][s] = stageM[s];
      if (CMASK[s]) expChan[c][s] = stageM[s];
    end
  endtask

  task automatic checkOutputs(string req);
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++)
        for (int s = 0; s < NS; s++) check(req, outLink(l, c, s), expLink[l][c][s]);
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) check(req, outChan(c, s), expChan[c][s]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    for (int l = 0; l < NL; l++) for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) expLink[l][c][s] = '0;
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) expChan[c][s] = '0;
    for (int s = 0; s < NS; s++) stageM[s] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 bValid", {31'd0, bValid}, 32'd0);
    check("R1 rValid", {31'd0, rValid}, 32'd0);
    check("R1 genCfg", genCfg[31:0] | genCfg[127:96], 32'd0);
    checkOutputs("R1 outputs");
    readCheck("R1 ctrl", 12'h000, 32'd0);
    readCheck("R1 sel", 12'h00C, 32'd0);
    readCheck("R1 gen", 12'h010, 32'd0);
    readCheck("R1 window", 12'h100, 32'd0);

    // R2 global words, all three arrival orders (R9)
    for (int g = 0; g < 4; g++) begin
      axiWrite(12'h010 + 12'(4*g), 32'hA000_0000 + 32'(g*32'h0102_0304), 4'hF, g % 3);
    end
    for (int g = 0; g < 4; g++) begin
      readCheck("R2 R9 gen readback", 12'h010 + 12'(4*g), 32'hA000_0000 + 32'(g*32'h0102_0304));
      check("R2 genCfg", genCfg[g*32 +: 32], 32'hA000_0000 + 32'(g*32'h0102_0304));
    end
    axiWrite(12'h014, 32'hFFFF_FFFF, 4'b0010, 1);
    readCheck("R2 byte strobe", 12'h014, (32'hA000_0000 + 32'h0102_0304) | 32'h0000_FF00);

    // R3 selector field positions
    axiWrite(12'h00C, 32'hFFFF_FFFF, 4'hF, 2);
    readCheck("R3 selector readback", 12'h00C, 32'h0100_0003);
    axiWrite(12'h00C, 32'h0000_0000, 4'hF, 0);
    readCheck("R3 selector cleared", 12'h00C, 32'h0);

    // R8 unmapped offsets
    axiWrite(12'h004, 32'h1234_5678, 4'hF, 0);
    axiWrite(12'h138, 32'h1234_5678, 4'hF, 1);
    axiWrite(12'h13C, 32'h1234_5678, 4'hF, 2);
    axiWrite(12'h011, 32'h1234_5678, 4'hF, 0);
    axiWrite(12'h200, 32'h1234_5678, 4'hF, 1);
    readCheck("R8 unmapped 004", 12'h004, 32'h0);
    readCheck("R8 unmapped slot14", 12'h138, 32'h0);
    readCheck("R8 unmapped slot15", 12'h13C, 32'h0);
    readCheck("R8 misaligned", 12'h011, 32'h0);
    readCheck("R8 outside map", 12'h200, 32'h0);
    readCheck("R8 gen untouched", 12'h010, 32'hA000_0000);
    check("R8 rresp", {30'd0, rResp}, 32'd0);

    // sweep every link and channel: stage, commit, check timing
    k = 0;
    for (int l = 0; l < NL; l++) begin
      for (int c = 0; c < NC; c++) begin
        axiWrite(12'h00C, (32'(l) << 24) | 32'(c), 4'hF, k % 3);
        for (int s = 0; s < NS; s++) begin
          if (LMASK[s] || CMASK[s]) begin
            axiWrite(12'h100 + 12'(4*s), val(l, c, s), 4'hF, k % 3);
            stageM[s] = val(l, c, s);
            k++;
          end
        end
        // R4 staged words not yet visible
        check("R4 staged not on output", outLink(l, c, 0), expLink[l][c][0]);
        check("R4 staged not on chanCfg", outChan(c, 6), expChan[c][6]);
        readCheck("R4 window shows committed", 12'h100, expLink[l][c][0]);
        axiWrite(12'h000, 32'h2, 4'hF, k % 3);
        check("R5 not before response edge", outLink(l, c, 1), expLink[l][c][1]);
        modelCommit(l, c);
        @(negedge clk);
        check("R5 visible one cycle later", outLink(l, c, 1), expLink[l][c][1]);
        check("R6 shared slot loaded", outChan(c, 7), expChan[c][7]);
        axiWrite(12'h000, 32'h0, 4'hF, 0);
      end
    end
    checkOutputs("R6 R5 full bank sweep");

    // R7 read-back of committed words per selector
    for (int l = 0; l < NL; l++) begin
      for (int c = 0; c < NC; c++) begin
        axiWrite(12'h00C, (32'(l) << 24) | 32'(c), 4'hF, 1);
        for (int s = 0; s < NS; s++) begin
          axiRead(12'h100 + 12'(4*s), d);
          if (LMASK[s]) check("R7 link slot", d, expLink[l][c][s]);
          else if (CMASK[s]) check("R7 shared slot", d, expChan[c][s]);
          else check("R8 window gap", d, 32'h0);
        end
      end
    end

    // R5 level held does not commit again
    axiWrite(12'h00C, 32'h0000_0002, 4'hF, 0);
    axiWrite(12'h000, 32'h2, 4'hF, 0);
    modelCommit(0, 2);
    @(negedge clk);
    check("R5 commit to link0 ch2", outLink(0, 2, 0), expLink[0][2][0]);
    axiWrite(12'h100, 32'hDEAD_BEEF, 4'hF, 2);
    stageM[0] = 32'hDEAD_BEEF;
    axiWrite(12'h000, 32'hFFFF_FFFF, 4'hF, 1);
    @(negedge clk); @(negedge clk);
    check("R5 held bit no commit", outLink(0, 2, 0), expLink[0][2][0]);
    readCheck("R5 ctrl readback", 12'h000, 32'h2);
    axiWrite(12'h000, 32'h0, 4'hF, 0);
    axiWrite(12'h000, 32'h2, 4'hF, 2);
    modelCommit(0, 2);
    @(negedge clk);
    check("R5 recommit after clear", outLink(0, 2, 0), 32'hDEAD_BEEF);
    checkOutputs("R5 final banks");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule